// File: doc/BRIEF.md
# Configuration Header Ratio Selector

This block sits beside a 32-bit configuration word stream and inspects its header without altering or forwarding it. It counts accepted words from zero, reads an encryption indication from header word 69 and a compression indication from header word 229, and combines those two flags with the configured data-path width (16 or 32 bits) to pick a clock-to-data ratio code for the configuration port.

The result appears on `ratio_code` together with a one-cycle `done` pulse in the cycle after word 229 is accepted. If the stream ends before that word has been seen, a one-cycle `err` pulse is raised and no ratio is produced. A synchronous `start` prepares the block for the next stream. The input is a valid/ready interface, but the block never applies back-pressure: `in_ready` is always high, and a word counts as accepted in any cycle where `in_valid` is high. Words offered after a result and before the next `start` pass through uninspected.

Top module: `hdr_ratio_sel`

## Requirements
- R1: A word is accepted in each cycle with `in_valid` high (`in_ready` is always 1). Cycles with `in_valid` low do not advance the zero-based word index.
- R2: The stream counts as encrypted when bits [3:2] of accepted word index 69 are not both zero. Other bits of that word have no effect.
- R3: The stream counts as compressed when bit 1 of accepted word index 229 is zero.
- R4: `done` is high for exactly one cycle, in the cycle after word index 229 is accepted. `ratio_code` takes its new value in that same cycle and holds it until the next result or `start`.
- R5: Ratio encoding is 0 = x1, 1 = x2, 2 = x4, 3 = x8. A stream that is neither encrypted nor compressed gives code 0 for either width.
- R6: A compressed stream gives code 2 when `wide_mode`=0 (16-bit) and code 3 when `wide_mode`=1 (32-bit), whether or not it is encrypted.
- R7: A stream that is encrypted but not compressed gives code 1 when `wide_mode`=0 and code 2 when `wide_mode`=1.
- R8: Only the value of `wide_mode` in the cycle that word 229 is accepted affects the result.
- R9: If a word with `in_last`=1 is accepted at index below 229, `err` is high for one cycle in the next cycle, with no `done` and `ratio_code` unchanged. A final word at index 229 gives `done` and no error.
- R10: `start` clears the word index, the captured encryption flag and `ratio_code` (to 0) on the next edge. A word offered in the same cycle as `start` is ignored.
- R11: After `done` or `err`, further words, including ones with `in_last`=1, produce no `done` or `err` until `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart for a new stream |
| wide_mode | input | 1 | Data-path width: 0 = 16-bit, 1 = 32-bit |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_data | input | 32 | Stream word |
| in_last | input | 1 | Marks the final word of the stream |
| ratio_code | output | 2 | Ratio code (0 x1, 1 x2, 2 x4, 3 x8) |
| done | output | 1 | One-cycle pulse when the ratio is valid |
| err | output | 1 | One-cycle pulse on a stream that is too short |

## Verification
The hardest cases to reach sit at the edge of the header: a stream that ends on index 228 must give an error, while one that ends on index 229 must give a result. Reaching them takes exactly 229 or 230 accepted words, with idle gaps mixed in so that the valid-low cycles are also shown not to count. The stimulus builds streams of chosen lengths, places chosen flag words at indexes 69 and 229, and changes `wide_mode` partway through a stream. It also asserts `start` in the same cycle as a valid word, and offers trailing words, some with `in_last` set, after a result. A behavioural model in the bench follows every cycle.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;
endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
  parameter int LIMIT = 230,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] cnt
);
  // Saturating zero-based index of the next word to be seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr)                        cnt <= '0;
    else if (adv && cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
  parameter int DATA_W = 32,
  parameter int CW     = 8,
  parameter int IDX    = 69,
  parameter int LSB    = 2,
  parameter int FW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [CW-1:0]     cnt,
  input  logic [DATA_W-1:0] data,
  output logic              flag
);
  // Latches "field is nonzero" from the word at a fixed header index.
  logic hit;
  assign hit = adv && (cnt == CW'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (hit) flag <= |data[LSB +: FW];
  end
endmodule

// File: rtl/hdr_ratio_encode.sv
module hdr_ratio_encode
  import hdr_pkg::*;
(
  input  logic   enc,
  input  logic   cmp,
  input  logic   wide,
  output ratio_e code
);
  // 16-bit base code; the 32-bit path adds one step unless the ratio is x1.
  ratio_e base;
  always_comb begin
    if (cmp)      base = RATIO_X4;
    else if (enc) base = RATIO_X2;
    else          base = RATIO_X1;

    if (wide && base != RATIO_X1) code = ratio_e'(base + 2'd1);
    else                          code = base;
  end
endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
  import hdr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic [1:0]        ratio_code,
  output logic              done,
  output logic              err
);
  localparam int HDR_WORDS = CMP_IDX + 1;
  localparam int CW        = $clog2(HDR_WORDS + 1);

  logic          closed_q;
  logic          adv;
  logic [CW-1:0] cnt;
  logic          enc_flag;
  logic          cmp_now;
  logic          at_cmp;
  ratio_e        code_now;
  ratio_e        ratio_q;

  assign in_ready = 1'b1;
  assign adv      = in_valid && in_ready && !closed_q && !start;
  assign at_cmp   = (cnt == CW'(CMP_IDX));
  assign cmp_now  = !in_data[CMP_BIT];

  hdr_word_counter #(.LIMIT(HDR_WORDS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv), .cnt(cnt)
  );

  hdr_flag_capture #(
    .DATA_W(DATA_W), .CW(CW), .IDX(ENC_IDX), .LSB(ENC_LSB), .FW(ENC_W)
  ) u_enc (
    .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv), .cnt(cnt),
    .data(in_data), .flag(enc_flag)
  );

  hdr_ratio_encode u_enc_code (
    .enc(enc_flag), .cmp(cmp_now), .wide(wide_mode), .code(code_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      err      <= 1'b0;
      closed_q <= 1'b0;
      ratio_q  <= RATIO_X1;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (start) begin
        closed_q <= 1'b0;
        ratio_q  <= RATIO_X1;
      end else if (adv) begin
        if (at_cmp) begin
          done     <= 1'b1;
          closed_q <= 1'b1;
          ratio_q  <= code_now;
        end else if (in_last) begin
          err      <= 1'b1;
          closed_q <= 1'b1;
        end
      end
    end
  end

  assign ratio_code = ratio_q;
endmodule

// File: rtl/hdr_ratio_sel_chk.sv
module hdr_ratio_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       wide_mode,
  input logic       in_valid,
  input logic       in_last,
  input logic [1:0] ratio_code,
  input logic       done,
  input logic       err
);
  assert_single_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && !start));

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> $stable(ratio_code));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_last && !start));

  assert_narrow_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(wide_mode)) |-> (ratio_code != 2'd3));

  assert_wide_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(wide_mode) && ratio_code != 2'd0) |-> (ratio_code >= 2'd2));

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ratio_code == 2'd0 && !done && !err));
endmodule

bind hdr_ratio_sel hdr_ratio_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
  .in_valid(in_valid), .in_last(in_last), .ratio_code(ratio_code),
  .done(done), .err(err)
);

// File: tb/tb_hdr_ratio_sel.sv
module tb_hdr_ratio_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [1:0]  ratio_code;
  logic        done;
  logic        err;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  hdr_ratio_sel dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .ratio_code(ratio_code), .done(done), .err(err)
  );

  // Behavioural reference model, advanced on each rising edge.
  int       m_idx = 0;
  bit       m_enc = 0;
  bit       m_closed = 0;
  bit       m_done = 0;
  bit       m_err = 0;
  bit [1:0] m_ratio = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_enc = 0; m_closed = 0; m_done = 0; m_err = 0; m_ratio = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (start) begin
        m_idx = 0; m_enc = 0; m_closed = 0; m_ratio = 0;
      end else if (in_valid && !m_closed) begin
        if (m_idx == 69) m_enc = (in_data[3:2] != 2'b00);
        if (m_idx == 229) begin
          if (!in_data[1])  m_ratio = wide_mode ? 2'd3 : 2'd2;
          else if (m_enc)   m_ratio = wide_mode ? 2'd2 : 2'd1;
          else              m_ratio = 2'd0;
          m_done = 1; m_closed = 1;
        end else if (in_last) begin
          m_err = 1; m_closed = 1;
        end
        m_idx++;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, "done", int'(done), int'(m_done));
      check(cur_req, "err", int'(err), int'(m_err));
      check(cur_req, "ratio_code", int'(ratio_code), int'(m_ratio));
      check("R1", "in_ready", int'(in_ready), 1);
    end
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [31:0] filler(int i);
    return {i[15:0], i[15:0]} ^ 32'hA5A5_5A5A;
  endfunction

  // Send n words; word 69 / 229 get the given contents. wide_at is the
  // width applied while word 229 is offered, its inverse at all other times.
  task automatic stream(int n, logic [31:0] w69, logic [31:0] w229,
                        bit wide_at, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) begin
        in_valid  = 1'b0;
        in_data   = 32'hFFFF_FFFF;
        in_last   = 1'b1;
        wide_mode = ~wide_at;
        @(negedge clk);
      end
      in_valid  = 1'b1;
      in_data   = (i == 69) ? w69 : (i == 229) ? w229 : filler(i);
      in_last   = (i == n - 1);
      wide_mode = (i == 229) ? wide_at : ~wide_at;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic restart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10", "ratio after start", int'(ratio_code), 0);
  endtask

  localparam logic [31:0] NOENC  = 32'hFFFF_FFF3; // bits[3:2]=00
  localparam logic [31:0] ENC_A  = 32'h0000_0004;
  localparam logic [31:0] ENC_B  = 32'h0000_0008;
  localparam logic [31:0] ENC_C  = 32'h0000_000C;
  localparam logic [31:0] NOCMP  = 32'h0000_0002; // bit1=1
  localparam logic [31:0] CMP    = 32'hFFFF_FFFD; // bit1=0

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset ratio", int'(ratio_code), 0);
    check("R4", "reset done", int'(done), 0);
    check("R9", "reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R5"; stream(230, NOENC, NOCMP, 1'b0, 1'b0);
    check("R5", "plain 16", int'(ratio_code), 0);
    restart(); stream(230, NOENC, NOCMP, 1'b1, 1'b0);
    check("R5", "plain 32", int'(ratio_code), 0);

    cur_req = "R7"; restart(); stream(230, ENC_A, NOCMP, 1'b0, 1'b0);
    check("R7", "enc 16", int'(ratio_code), 1);
    restart(); stream(230, ENC_B, NOCMP, 1'b1, 1'b1);
    check("R7", "enc 32", int'(ratio_code), 2);

    cur_req = "R2"; restart(); stream(230, NOENC, NOCMP, 1'b1, 1'b0);
    check("R2", "low bits ignored", int'(ratio_code), 0);

    cur_req = "R6"; restart(); stream(230, NOENC, CMP, 1'b0, 1'b0);
    check("R6", "cmp 16", int'(ratio_code), 2);
    restart(); stream(230, ENC_C, CMP, 1'b1, 1'b0);
    check("R6", "enc+cmp 32", int'(ratio_code), 3);
    cur_req = "R3"; restart(); stream(230, ENC_C, CMP, 1'b0, 1'b1);
    check("R3", "enc+cmp 16", int'(ratio_code), 2);

    cur_req = "R8"; restart(); stream(240, ENC_A, NOCMP, 1'b1, 1'b0);
    check("R8", "width at word 229", int'(ratio_code), 2);

    cur_req = "R9"; restart(); stream(100, ENC_A, CMP, 1'b1, 1'b0);
    check("R9", "short keeps ratio", int'(ratio_code), 0);
    restart(); stream(229, ENC_A, CMP, 1'b1, 1'b1);
    check("R9", "229 words", int'(ratio_code), 0);
    cur_req = "R4"; restart(); stream(230, ENC_A, CMP, 1'b1, 1'b1);
    check("R4", "230 words", int'(ratio_code), 3);

    cur_req = "R11"; stream(20, ENC_A, NOCMP, 1'b0, 1'b0);
    check("R11", "trailing ignored", int'(ratio_code), 3);

    // R10: start coincides with a valid word, which must not be counted.
    cur_req = "R10";
    start = 1'b1; in_valid = 1'b1; in_data = filler(0); in_last = 1'b1;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    check("R10", "cleared", int'(ratio_code), 0);
    stream(230, ENC_B, NOCMP, 1'b0, 1'b0);
    check("R10", "count from zero", int'(ratio_code), 1);

    // R10: start mid-stream drops the captured encryption flag.
    restart(); stream(120, ENC_A, NOCMP, 1'b0, 1'b0);
    restart(); stream(230, NOENC, NOCMP, 1'b0, 1'b0);
    check("R10", "flag cleared", int'(ratio_code), 0);

    cur_req = "R1"; restart(); stream(230, ENC_C, NOCMP, 1'b1, 1'b1);
    check("R1", "gaps not counted", int'(ratio_code), 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule